// File: doc/BRIEF.md
# Serial-Input DAC Word Capture Front End

This block is the digital side of a 12-bit serial-input digital-to-analog converter. Serial data is clocked into an input shift register by any one of four strobe pins. Three of the strobes capture on a rising edge and one captures on a falling edge. Each strobe is accepted only when the other three are at the right levels, so one strobe can be steered in while the others act as enables. The bit pushed out of the top of the shift register is driven on a serial output, so several converters can share one data line in a chain. A holding register presents the converter code. It copies the shift register whenever two active-low load inputs are both asserted. An active-low clear input forces the holding register to zero without waiting for a clock.

All strobe, data and load pins are sampled by a fast system clock through multi-flop synchronizers, and every edge is found synchronously. The strobe that uses the opposite edge is chosen by a parameter. A load may arrive in the same sampled cycle as the last strobe edge of a word. The holding register then captures the word including that last bit.

Top module: `serial_dac_front`

## Requirements
- R1: Strobes 0, 1 and 3 each shift one bit in on their rising edge, but only while strobe 2 is high and the other two of strobes 0, 1 and 3 are low.
- R2: Strobe 2 shifts one bit in on its falling edge, but only while strobes 0, 1 and 3 are all low.
- R3: Strobe transitions that break the qualifying levels of R1 and R2 leave the shift register and the serial output unchanged. This includes two strobes changing in the same cycle.
- R4: A word is 12 bits, sent most significant bit first. After 12 accepted edges and a load, the first bit sent sits in bit 11 of the converter code.
- R5: The serial output is bit 11 of the shift register and changes only when a shift is accepted. During a word it presents the previous word's bits, from bit 10 down to bit 0, and after the twelfth shift it presents the new word's bit 11.
- R6: The holding register copies the shift register in every cycle in which both load inputs are sampled low. With only one load input low, or with neither low, it holds its value.
- R7: When both load inputs first appear low in the same sampled cycle as an accepted strobe edge, the holding register takes the shift register value that includes the newly shifted bit.
- R8: While clear is low, the converter code is zero. This happens at once, without a clock edge, and it overrides any load. Clear leaves the shift register unchanged.
- R9: A pin change is seen at the outputs on the third rising clock edge after it, and not earlier: two synchronizer stages and one result register.
- R10: After system reset, the converter code and the serial output are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast system sampling clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| strobe_i | input | 4 | Strobe pins; bit 2 captures on falling edge, others on rising |
| ser_in | input | 1 | Serial data input |
| ld_a_n | input | 1 | First active-low load input |
| ld_b_n | input | 1 | Second active-low load input |
| clr_n | input | 1 | Asynchronous active-low clear of the converter code |
| ser_out | output | 1 | Chain output, top bit of the shift register |
| dac_code | output | 12 | Holding register value driving the converter |

## Verification
Every strobe, data and load change reaches the shift register, the serial output and the converter code on the third rising clock edge after the change. The bench changes inputs on falling edges and holds each strobe level for four cycles. It samples results on the fourth falling edge, after the third rising edge. In one test the loads are asserted together with the final strobe edge. There the code is checked on the second falling edge, where it must still show the old word, and on the third, where it must show the new word. Clear acts without a clock, so it is checked one nanosecond after clear falls, before any rising edge.

// File: rtl/sdf_pkg.sv
package sdf_pkg;
   localparam int unsigned STROBE_CNT = 4;

   typedef enum logic {
      EDGE_RISE = 1'b0,
      EDGE_FALL = 1'b1
   } edge_kind_e;

   function automatic edge_kind_e edge_of(input int unsigned idx, input int unsigned fall_idx);
      return (idx == fall_idx) ? EDGE_FALL : EDGE_RISE;
   endfunction
endpackage

// File: rtl/sdf_sync.sv
module sdf_sync #(
   parameter int unsigned W      = 1,
   parameter int unsigned STAGES = 2,
   parameter logic [W-1:0] RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [STAGES-1:0][W-1:0] stg;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg <= {STAGES{RST_VAL}};
      else        stg <= {stg[STAGES-2:0], d};
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/sdf_strobe_qual.sv
module sdf_strobe_qual
   import sdf_pkg::*;
#(
   parameter int unsigned N        = STROBE_CNT,
   parameter int unsigned FALL_IDX = 2
) (
   input  logic [N-1:0] lvl,
   input  logic [N-1:0] prev,
   output logic [N-1:0] fire,
   output logic         shift_en
);
   localparam logic [N-1:0] ONE       = 1;
   localparam logic [N-1:0] FALL_BIT  = ONE << FALL_IDX;
   localparam logic [N-1:0] RISE_MASK = ~FALL_BIT;

   for (genvar i = 0; i < N; i++) begin : g_strb
      if (edge_of(i, FALL_IDX) == EDGE_FALL) begin : g_fall
         assign fire[i] = prev[i] & ~lvl[i] & ~|(lvl & RISE_MASK);
      end else begin : g_rise
         localparam logic [N-1:0] PEERS = RISE_MASK & ~(ONE << i);
         assign fire[i] = ~prev[i] & lvl[i] & lvl[FALL_IDX] & ~|(lvl & PEERS);
      end
   end

   assign shift_en = |fire;
endmodule

// File: rtl/sdf_shift.sv
module sdf_shift #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         shift_en,
   input  logic         din,
   output logic [W-1:0] sr_q,
   output logic [W-1:0] sr_next
);
   assign sr_next = shift_en ? {sr_q[W-2:0], din} : sr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sr_q <= '0;
      else        sr_q <= sr_next;
   end
endmodule

// File: rtl/sdf_hold.sv
module sdf_hold #(
   parameter int unsigned W = 12
) (
   input  logic         clk,
   input  logic         arst_n,
   input  logic         load_en,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n)      q <= '0;
      else if (load_en) q <= d;
   end
endmodule

// File: rtl/serial_dac_front.sv
module serial_dac_front
   import sdf_pkg::*;
#(
   parameter int unsigned WORD_W      = 12,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned FALL_IDX    = 2
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [STROBE_CNT-1:0] strobe_i,
   input  logic                  ser_in,
   input  logic                  ld_a_n,
   input  logic                  ld_b_n,
   input  logic                  clr_n,
   output logic                  ser_out,
   output logic [WORD_W-1:0]     dac_code
);
   localparam int unsigned N  = STROBE_CNT;
   localparam int unsigned SW = N + 3;
   localparam logic [SW-1:0] SYNC_RST = {2'b11, {(N + 1){1'b0}}};

   if (WORD_W < 2) begin : g_bad_width
      $error("WORD_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (FALL_IDX >= N) begin : g_bad_fall
      $error("FALL_IDX must select one of the strobes");
   end

   logic [SW-1:0]     raw_pins, syn_pins;
   logic [N-1:0]      strb_lvl, strb_prev, strb_fire;
   logic              din_s, ld_a_s, ld_b_s;
   logic              shift_en, load_en, hold_arst_n;
   logic [WORD_W-1:0] sr_q, sr_next;

   assign raw_pins = {ld_b_n, ld_a_n, ser_in, strobe_i};

   sdf_sync #(.W(SW), .STAGES(SYNC_STAGES), .RST_VAL(SYNC_RST)) u_sync (
      .clk(clk), .rst_n(rst_n), .d(raw_pins), .q(syn_pins)
   );

   assign strb_lvl = syn_pins[N-1:0];
   assign din_s    = syn_pins[N];
   assign ld_a_s   = syn_pins[N+1];
   assign ld_b_s   = syn_pins[N+2];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) strb_prev <= '0;
      else        strb_prev <= strb_lvl;
   end

   sdf_strobe_qual #(.N(N), .FALL_IDX(FALL_IDX)) u_qual (
      .lvl(strb_lvl), .prev(strb_prev), .fire(strb_fire), .shift_en(shift_en)
   );

   sdf_shift #(.W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(shift_en), .din(din_s),
      .sr_q(sr_q), .sr_next(sr_next)
   );

   assign load_en     = ~ld_a_s & ~ld_b_s;
   assign hold_arst_n = rst_n & clr_n;

   sdf_hold #(.W(WORD_W)) u_hold (
      .clk(clk), .arst_n(hold_arst_n), .load_en(load_en), .d(sr_next), .q(dac_code)
   );

   assign ser_out = sr_q[WORD_W-1];
endmodule

// File: rtl/serial_dac_front_chk.sv
module serial_dac_front_chk #(
   parameter int unsigned WORD_W = 12
) (
   input logic              clk,
   input logic              rst_n,
   input logic              clr_n,
   input logic              shift_en,
   input logic              load_en,
   input logic              din_s,
   input logic [WORD_W-1:0] sr_q,
   input logic              ser_out,
   input logic [WORD_W-1:0] dac_code
);
   assert_clear_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
      !clr_n |-> dac_code == '0);

   assert_idle_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(sr_q));

   assert_shift_lsb_R4: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> sr_q[0] == $past(din_s));

   assert_chain_out_R5: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> ser_out == $past(sr_q[WORD_W-2]));

   assert_no_load_hold_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      !load_en |=> $stable(dac_code));

   assert_load_copy_R6: assert property (@(posedge clk) disable iff (!rst_n || !clr_n)
      (load_en && !shift_en) |=> dac_code == sr_q);
endmodule

bind serial_dac_front serial_dac_front_chk #(.WORD_W(WORD_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .shift_en(shift_en),
   .load_en(load_en), .din_s(din_s), .sr_q(sr_q), .ser_out(ser_out),
   .dac_code(dac_code)
);

// File: tb/serial_dac_front_test.sv
`timescale 1ns/1ps
module serial_dac_front_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic [3:0]  strobe_i;
   logic        ser_in, ld_a_n, ld_b_n, clr_n;
   logic        ser_out;
   logic [11:0] dac_code;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   logic [11:0] exp_sr = '0;
   bit          exp_q[$];
   event        mon_ev;
   string       mon_tag;

   always #2.5 clk = ~clk;

   serial_dac_front uut (
      .clk(clk), .rst_n(rst_n), .strobe_i(strobe_i), .ser_in(ser_in),
      .ld_a_n(ld_a_n), .ld_b_n(ld_b_n), .clr_n(clr_n),
      .ser_out(ser_out), .dac_code(dac_code)
   );

   task automatic chk(input string tag, input logic [11:0] act, input logic [11:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wait_neg(input int n);
      repeat (n) @(negedge clk);
   endtask

   // monitor: pops the expected chain output after each strobe edge
   initial begin
      forever begin
         @(mon_ev);
         if (exp_q.size() == 0) chk({mon_tag, " R5 queue empty"}, 12'h1, 12'h0);
         else begin
            bit e;
            e = exp_q.pop_front();
            chk({mon_tag, " R5 ser_out"}, {11'b0, ser_out}, {11'b0, e});
         end
      end
   end

   // driver: one accepted strobe edge; optional load in the same cycle (R7, R9)
   task automatic shift_bit(input int m, input bit b, input bit with_load,
                            input logic [11:0] old_code);
      exp_q.push_back(exp_sr[10]);
      exp_sr = {exp_sr[10:0], b};
      ser_in = b;
      if (m == 2) strobe_i[2] = 1'b0;
      else        strobe_i[m] = 1'b1;
      if (with_load) begin
         ld_a_n = 1'b0;
         ld_b_n = 1'b0;
         wait_neg(2);
         chk("R9 code not yet updated", dac_code, old_code);
         wait_neg(1);
         chk("R7 load with last edge", dac_code, exp_sr);
         wait_neg(1);
      end else begin
         wait_neg(4);
      end
      mon_tag = (m == 2) ? "R2" : "R1";
      ->mon_ev;
      if (m == 2) strobe_i[2] = 1'b1;
      else        strobe_i[m] = 1'b0;
      ld_a_n = 1'b1;
      ld_b_n = 1'b1;
      wait_neg(4);
   endtask

   task automatic send_word(input int m, input logic [11:0] w, input bit load_last,
                            input logic [11:0] old_code);
      for (int k = 11; k >= 0; k--) shift_bit(m, w[k], load_last && (k == 0), old_code);
   endtask

   task automatic load_both();
      ld_a_n = 1'b0;
      ld_b_n = 1'b0;
      wait_neg(4);
      ld_a_n = 1'b1;
      ld_b_n = 1'b1;
      wait_neg(2);
   endtask

   initial begin
      rst_n = 1'b0; strobe_i = 4'b0100; ser_in = 1'b0;
      ld_a_n = 1'b1; ld_b_n = 1'b1; clr_n = 1'b1;
      wait_neg(3);
      chk("R10 reset code", dac_code, 12'h000);
      chk("R10 reset ser_out", {11'b0, ser_out}, 12'h000);
      rst_n = 1'b1;
      wait_neg(2);

      // strobe 0, rising
      send_word(0, 12'hA5C, 1'b0, 12'h000);
      chk("R6 no load with both high", dac_code, 12'h000);
      ld_a_n = 1'b0; wait_neg(4);
      chk("R6 only first load low", dac_code, 12'h000);
      ld_a_n = 1'b1; ld_b_n = 1'b0; wait_neg(4);
      chk("R6 only second load low", dac_code, 12'h000);
      ld_b_n = 1'b1; wait_neg(2);
      load_both();
      chk("R1 R4 strobe0 word", dac_code, 12'hA5C);

      // strobe 1, rising
      send_word(1, 12'h3C7, 1'b0, 12'hA5C);
      load_both();
      chk("R1 R4 strobe1 word", dac_code, 12'h3C7);

      // strobe 3, rising
      send_word(3, 12'h91E, 1'b0, 12'h3C7);
      load_both();
      chk("R1 R4 strobe3 word", dac_code, 12'h91E);

      // strobe 2, falling, load with last edge
      send_word(2, 12'h6B3, 1'b1, 12'h91E);
      chk("R2 R4 strobe2 word", dac_code, 12'h6B3);

      // clear: asynchronous, overrides load
      clr_n = 1'b0;
      #1;
      chk("R8 clear without clock", dac_code, 12'h000);
      ld_a_n = 1'b0; ld_b_n = 1'b0;
      wait_neg(4);
      chk("R8 clear beats load", dac_code, 12'h000);
      ld_a_n = 1'b1; ld_b_n = 1'b1;
      wait_neg(2);
      clr_n = 1'b1;
      wait_neg(4);
      chk("R8 stays zero after release", dac_code, 12'h000);

      // disallowed strobe combinations
      ser_in = 1'b1;
      strobe_i = 4'b0111; wait_neg(4);
      strobe_i = 4'b0011; wait_neg(4);
      strobe_i = 4'b0100; wait_neg(4);
      strobe_i = 4'b0001; wait_neg(4);
      strobe_i = 4'b0100; wait_neg(4);
      strobe_i = 4'b1110; wait_neg(4);
      strobe_i = 4'b0100; wait_neg(4);
      chk("R3 ser_out unchanged", {11'b0, ser_out}, {11'b0, exp_sr[11]});
      load_both();
      chk("R3 R8 shift register untouched", dac_code, 12'h6B3);

      // chain output of the previous word through another word
      send_word(0, 12'h0F0, 1'b0, 12'h6B3);
      load_both();
      chk("R1 R5 final word", dac_code, 12'h0F0);

      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog R10 actual=%h expected=%h", 12'h0, 12'h1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule